// File: doc/BRIEF.md
# Cascaded Low-Frequency Watchdog

This block is a watchdog with three counters that all run on the slow always-on clock. Each counter has a match value and a two-bit mode. When a counter reaches its match value it wraps to zero, and it raises its interrupt flag if its mode is not off. Software keeps the system alive in one of two ways: it acknowledges each interrupt, or it clears the counter before the match comes around. If a counter in an escalating mode matches a third time in a row without an acknowledge, the block emits a one-cycle system reset pulse.

Counter 0 can feed counter 1. With the cascade bit set, counter 1 advances once per counter 0 match instead of on every clock. A short period on counter 0 (for example a wake-up tick with interrupt-only mode) can then sit under a long escalating period on counter 1. Configuration goes through a small write-only register port: three match registers, a control word holding the modes and the cascade bit, and a command word carrying clear and acknowledge strobes.

Top module: `lfwd_top`

## Requirements
- R1: After reset every counter is zero. A counter advances by one per clock, and on the clock where it equals its match value M it returns to zero, so its match events repeat every M+1 clocks.
- R2: Counters 0 and 1 are 16 bits wide and compare only bits 15:0 of their match register. Counter 2 is 32 bits wide and uses the full register. Match registers sit at addresses 0, 1 and 2.
- R3: A match event sets that counter's flag (`irq_flags[i]`, visible after the matching edge) when its mode is 1, 2 or 3. With mode 0 the flag is not set. The control word at address 3 holds the mode of counter i in bits 2i+1:2i.
- R4: A counter that is cleared more often than its match period never sets its flag and never causes a reset.
- R5: When a counter whose mode is 2 or 3 matches while its count of unhandled matches is already two, `sys_rst` is high for exactly one cycle, aligned with the flag update. That count then restarts from zero.
- R6: A counter in mode 1 sets its flag but never produces a reset, however many matches go unacknowledged.
- R7: Writing 1 to bit i of the command word (address 4) clears counter i two clocks later. `clr_pending[i]` is high for those two cycles, and the zeroing clock produces no match event.
- R8: Writing 1 to bit 4+i of the command word clears flag i and zeroes its unhandled-match count. A match on the same clock counts as a first new event.
- R9: With bit 8 of the control word set, counter 1 advances only on counter 0 match events.
- R10: `irq` is the OR of the flags whose counter mode is not 0.
- R11: Reset sets all match registers to zero, all modes to 0 and the cascade bit to 0. All outputs are low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Low-frequency counting clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0-2 match, 3 control, 4 command) |
| wr_data | input | 32 | Write data |
| irq | output | 1 | Combined interrupt request |
| sys_rst | output | 1 | One-cycle system reset pulse |
| irq_flags | output | 3 | Per-counter interrupt flags |
| clr_pending | output | 3 | Per-counter clear in progress |

## Verification
The assertions take for granted that the reset is held for at least one clock before any write, and that the write port carries at most one write per clock with stable data. The bench drives every write for exactly one cycle from the falling edge and holds reset over several edges at start-up. Clear requests are never issued back-to-back on one counter faster than the checks expect. No match value is lowered below a running count except right after a clear, so no counter runs through its full 16-bit or 32-bit range.

// File: rtl/lfwd_pkg.sv
// Package: shared constants for the low-frequency watchdog.
// Assumes three counters; the register map offsets are fixed here.
package lfwd_pkg;
    localparam int NCH = 3;

    typedef enum logic [1:0] {
        MD_OFF   = 2'd0,
        MD_IRQ   = 2'd1,
        MD_ESC   = 2'd2,
        MD_ESC_B = 2'd3
    } lfwd_mode_e;

    localparam logic [2:0] A_MATCH0 = 3'd0;
    localparam logic [2:0] A_MATCH1 = 3'd1;
    localparam logic [2:0] A_MATCH2 = 3'd2;
    localparam logic [2:0] A_CTRL   = 3'd3;
    localparam logic [2:0] A_CMD    = 3'd4;

    localparam int CASC_BIT = 8;
    localparam int ACK_LSB  = 4;
    localparam int UNH_LIM  = 2;
endpackage

// File: rtl/lfwd_regs.sv
// Module: configuration registers and command strobes.
// Holds match values, modes and the cascade bit. The clear and
// acknowledge strobes are decoded straight from the write port and last
// for the single cycle of the write. Assumes one write per clock at most.
module lfwd_regs
    import lfwd_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 3
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [ADDR_W-1:0]                wr_addr,
    input  logic [DATA_W-1:0]                wr_data,
    output logic [NCH-1:0][DATA_W-1:0]       match_o,
    output logic [NCH-1:0][1:0]              mode_o,
    output logic                             cascade_o,
    output logic [NCH-1:0]                   clr_req_o,
    output logic [NCH-1:0]                   ack_o
);
    logic cmd_wr;

    // Register writes; reset leaves matches at zero and all modes off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_o   <= '0;
            mode_o    <= '0;
            cascade_o <= 1'b0;
        end else if (wr_en) begin
            case (wr_addr)
                ADDR_W'(A_MATCH0): match_o[0] <= wr_data;
                ADDR_W'(A_MATCH1): match_o[1] <= wr_data;
                ADDR_W'(A_MATCH2): match_o[2] <= wr_data;
                ADDR_W'(A_CTRL): begin
                    for (int i = 0; i < NCH; i++) mode_o[i] <= wr_data[2*i +: 2];
                    cascade_o <= wr_data[CASC_BIT];
                end
                default: ;
            endcase
        end
    end

    // Command strobes: write-one pulses for clear and acknowledge.
    always_comb begin
        cmd_wr = wr_en && (wr_addr == ADDR_W'(A_CMD));
        for (int i = 0; i < NCH; i++) begin
            clr_req_o[i] = cmd_wr && wr_data[i];
            ack_o[i]     = cmd_wr && wr_data[ACK_LSB + i];
        end
    end
endmodule

// File: rtl/lfwd_channel.sv
// Module: one watchdog counter with its flag and escalation count.
// Counts on tick_i, wraps on match, and tracks unhandled matches. A
// clear request passes two synchroniser stages before it zeroes the
// counter. Assumes match_i and mode_i are stable register outputs.
module lfwd_channel
    import lfwd_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    input  logic [W-1:0] match_i,
    input  logic [1:0]   mode_i,
    input  logic         clr_req_i,
    input  logic         ack_i,
    output logic         evt_o,
    output logic         flag_o,
    output logic         fire_o,
    output logic         clr_pend_o
);
    logic [W-1:0] cnt_q;
    logic [1:0]   sync_q;
    logic [1:0]   unh_q;
    logic [1:0]   unh_base;
    logic         clr_apply;
    logic         act_en;

    // Match detection and escalation decision for this cycle.
    always_comb begin
        clr_apply  = sync_q[1];
        act_en     = (mode_i != 2'(MD_OFF));
        evt_o      = tick_i && !clr_apply && (cnt_q == match_i);
        unh_base   = ack_i ? 2'd0 : unh_q;
        fire_o     = evt_o && mode_i[1] && (unh_base == 2'(UNH_LIM));
        clr_pend_o = |sync_q;
    end

    // Counter: zero on clear or match, else advance on tick.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt_q <= '0;
        else if (clr_apply)  cnt_q <= '0;
        else if (evt_o)      cnt_q <= '0;
        else if (tick_i)     cnt_q <= cnt_q + 1'b1;
    end

    // Two-stage delay line for the clear request.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[0], clr_req_i};
    end

    // Unhandled-match count: bumps on enabled match, restarts after escalation.
    always_ff @(posedge clk) begin
        if (!rst_n)                 unh_q <= '0;
        else if (evt_o && act_en)   unh_q <= (unh_base == 2'(UNH_LIM)) ? 2'd0 : unh_base + 2'd1;
        else if (clr_apply || ack_i) unh_q <= '0;
    end

    // Interrupt flag: set on enabled match, cleared by acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)               flag_o <= 1'b0;
        else if (evt_o && act_en) flag_o <= 1'b1;
        else if (ack_i)           flag_o <= 1'b0;
    end

    // R5
    fire_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |-> flag_o);
    // R5
    fire_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |=> !fire_o);
    // R7
    clr_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_req_i |=> clr_pend_o);
    // R7
    clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_req_i |-> ##3 (cnt_q == '0));
    // R3
    flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_o) |-> $past(evt_o && act_en));
endmodule

// File: rtl/lfwd_top.sv
// Module: top of the cascaded low-frequency watchdog.
// Builds three counters (two narrow, one wide), routes counter 0 match
// events into counter 1 when cascade is set, merges the interrupt flags
// and registers the reset pulse. Assumes DATA_W >= HI_W.
module lfwd_top
    import lfwd_pkg::*;
#(
    parameter int LO_W   = 16,
    parameter int HI_W   = 32,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              irq,
    output logic              sys_rst,
    output logic [NCH-1:0]    irq_flags,
    output logic [NCH-1:0]    clr_pending
);
    logic [NCH-1:0][DATA_W-1:0] match_q;
    logic [NCH-1:0][1:0]        mode_q;
    logic                       cascade_q;
    logic [NCH-1:0]             clr_req;
    logic [NCH-1:0]             ack;
    logic [NCH-1:0]             evt;
    logic [NCH-1:0]             fire;
    logic [NCH-1:0]             irq_src;

    lfwd_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .match_o   (match_q),
        .mode_o    (mode_q),
        .cascade_o (cascade_q),
        .clr_req_o (clr_req),
        .ack_o     (ack)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        localparam int W = (i == NCH - 1) ? HI_W : LO_W;
        logic tick;

        if (i == 1) begin : g_casc
            assign tick = cascade_q ? evt[0] : 1'b1;
        end else begin : g_free
            assign tick = 1'b1;
        end

        lfwd_channel #(.W(W)) u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .tick_i     (tick),
            .match_i    (match_q[i][W-1:0]),
            .mode_i     (mode_q[i]),
            .clr_req_i  (clr_req[i]),
            .ack_i      (ack[i]),
            .evt_o      (evt[i]),
            .flag_o     (irq_flags[i]),
            .fire_o     (fire[i]),
            .clr_pend_o (clr_pending[i])
        );

        assign irq_src[i] = irq_flags[i] && (mode_q[i] != 2'(MD_OFF));
    end

    assign irq = |irq_src;

    // Reset pulse register, high for one cycle per escalation.
    always_ff @(posedge clk) begin
        if (!rst_n) sys_rst <= 1'b0;
        else        sys_rst <= |fire;
    end

    // R10
    irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (|irq_flags));
endmodule

// File: tb/lfwd_top_tb.sv
module lfwd_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        irq, sys_rst;
    logic [2:0]  irq_flags, clr_pending;

    int n_chk = 0;
    int n_bad = 0;
    int rst_seen = 0;
    bit cmp_on = 1'b0;
    bit done = 1'b0;

    lfwd_top u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .irq(irq), .sys_rst(sys_rst),
        .irq_flags(irq_flags), .clr_pending(clr_pending)
    );

    always #5 clk = ~clk;

    // Behavioural reference model
    logic [31:0] m_cnt [3];
    logic [31:0] m_match [3];
    logic [1:0]  m_mode [3];
    int          m_unh [3];
    logic        m_flag [3];
    logic        m_s0 [3];
    logic        m_s1 [3];
    logic        m_cas, m_rst;

    always @(posedge clk) begin
        logic [31:0] msk, mt;
        logic ev [3];
        logic tk, ack, fire_any, cmd;
        int base;
        if (!rst_n) begin
            for (int i = 0; i < 3; i++) begin
                m_cnt[i] = 0; m_match[i] = 0; m_mode[i] = 0; m_unh[i] = 0;
                m_flag[i] = 0; m_s0[i] = 0; m_s1[i] = 0;
            end
            m_cas = 0; m_rst = 0;
        end else begin
            cmd = wr_en && wr_addr == 3'd4;
            for (int i = 0; i < 3; i++) begin
                msk = (i == 2) ? 32'hFFFF_FFFF : 32'h0000_FFFF;
                mt  = m_match[i] & msk;
                tk  = (i == 1 && m_cas) ? ev[0] : 1'b1;
                ev[i] = tk && !m_s1[i] && (m_cnt[i] == mt);
                if (m_s1[i] || ev[i]) m_cnt[i] = 0;
                else if (tk) m_cnt[i] = (m_cnt[i] + 1) & msk;
            end
            fire_any = 0;
            for (int i = 0; i < 3; i++) begin
                ack  = cmd && wr_data[4+i];
                base = ack ? 0 : m_unh[i];
                if (ev[i] && m_mode[i] != 0) begin
                    if (base == 2 && m_mode[i] >= 2) fire_any = 1;
                    m_unh[i] = (base == 2) ? 0 : base + 1;
                    m_flag[i] = 1;
                end else begin
                    if (m_s1[i] || ack) m_unh[i] = 0;
                    if (ack) m_flag[i] = 0;
                end
                m_s1[i] = m_s0[i];
                m_s0[i] = cmd && wr_data[i];
            end
            m_rst = fire_any;
            if (wr_en) begin
                if (wr_addr <= 3'd2) m_match[wr_addr] = wr_data;
                if (wr_addr == 3'd3) begin
                    for (int i = 0; i < 3; i++) m_mode[i] = wr_data[2*i +: 2];
                    m_cas = wr_data[8];
                end
            end
        end
    end

    task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (cmp_on) begin
            chk(irq_flags, {m_flag[2], m_flag[1], m_flag[0]}, "R1 R3 flags vs model");
            chk(clr_pending, {m_s0[2]|m_s1[2], m_s0[1]|m_s1[1], m_s0[0]|m_s1[0]}, "R7 pending vs model");
            chk(sys_rst, m_rst, "R5 reset pulse vs model");
            chk(irq, (m_flag[0] && m_mode[0] != 0) || (m_flag[1] && m_mode[1] != 0) ||
                     (m_flag[2] && m_mode[2] != 0), "R10 irq vs model");
            if (sys_rst) rst_seen++;
        end
    end

    // Called at a falling edge; holds the write for one cycle.
    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        chk(irq_flags, 3'b000, "R11 flags after reset");
        chk(irq, 1'b0, "R11 irq after reset");
        chk(sys_rst, 1'b0, "R11 sys_rst after reset");
        chk(clr_pending, 3'b000, "R11 pending after reset");

        // Interrupt-only on counter 0; upper match bits must be ignored
        wr(3'd0, 32'h0001_0003);
        wr(3'd3, 32'h0000_0001);
        repeat (14) @(negedge clk);
        chk(irq_flags[0], 1'b1, "R2 R3 flag0 with truncated match");
        chk(irq, 1'b1, "R10 irq from flag0");
        chk(rst_seen, 0, "R6 no reset in interrupt-only mode");

        // Mode off masks irq; ack clears flag; no new flag with mode off
        wr(3'd3, 32'h0000_0000);
        chk(irq, 1'b0, "R10 irq masked by mode off");
        wr(3'd4, 32'h0000_0010);
        chk(irq_flags[0], 1'b0, "R8 ack clears flag0");
        repeat (12) @(negedge clk);
        chk(irq_flags[0], 1'b0, "R3 mode off sets no flag");

        // Escalation: third unhandled match pulses reset once
        rst_seen = 0;
        wr(3'd3, 32'h0000_0002);
        repeat (15) @(negedge clk);
        chk(rst_seen, 1, "R5 one reset pulse after three matches");
        // Regular acknowledges hold off escalation
        rst_seen = 0;
        for (int k = 0; k < 10; k++) begin
            wr(3'd4, 32'h0000_0010);
            repeat (3) @(negedge clk);
        end
        chk(rst_seen, 0, "R8 acknowledges prevent reset");
        wr(3'd3, 32'h0000_0000);
        wr(3'd4, 32'h0000_0010);

        // Counter 2: frequent clears prevent any flag
        wr(3'd2, 32'd5);
        wr(3'd4, 32'h0000_0004);
        wr(3'd3, 32'h0000_0020);
        rst_seen = 0;
        for (int k = 0; k < 8; k++) begin
            wr(3'd4, 32'h0000_0004);
            chk(clr_pending[2], 1'b1, "R7 pending first cycle");
            @(negedge clk);
            chk(clr_pending[2], 1'b1, "R7 pending second cycle");
            @(negedge clk);
            chk(clr_pending[2], 1'b0, "R7 pending drops after clear");
        end
        chk(irq_flags[2], 1'b0, "R4 cleared counter sets no flag");
        chk(rst_seen, 0, "R4 cleared counter causes no reset");
        repeat (20) @(negedge clk);
        chk(irq_flags[2], 1'b1, "R2 R3 counter 2 flags once clears stop");
        wr(3'd3, 32'h0000_0000);
        wr(3'd4, 32'h0000_0040);

        // Cascade: counter 1 counts counter 0 matches
        wr(3'd0, 32'd1);
        wr(3'd1, 32'd2);
        wr(3'd3, 32'h0000_0100);
        wr(3'd4, 32'h0000_0003);
        wr(3'd3, 32'h0000_0104);
        repeat (5) @(negedge clk);
        chk(irq_flags[1], 1'b0, "R9 cascaded counter 1 not yet matched");
        repeat (2) @(negedge clk);
        chk(irq_flags[1], 1'b1, "R9 cascaded counter 1 matched");
        repeat (20) @(negedge clk);

        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            finish_run();
        end
    end
endmodule